// File: doc/BRIEF.md
# Supply Lockout Write-Inhibit Timer

This block decides when a serial nonvolatile memory may begin a write. It watches a digital flag that says the supply is at or above the lockout threshold. While that flag is low, no new write may begin. Once the flag comes up and stays up, the block waits a fixed hold-off, given in clock cycles, before it opens write permission. This gives a host controller time to finish its start-up work while stray writes stay blocked. Reads pass through at all times.

The flag arrives from an analog comparator and may change at any moment, so it first crosses a chain of flops. Any dip of the flag during the hold-off sends the wait back to zero. A write that is already running when the flag drops is not stopped by this block, but it is reported on a one-cycle abort pulse so that the memory core can mark the cell as suspect.

Top module: `supply_write_gate`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `wr_permit`, `wr_grant` and `wr_abort` are all 0.
- R2: `supply_ok_raw` passes through a synchroniser of SYNC_STAGES flops (default 2) before use. A change on it cannot reach `wr_permit` before the second rising edge that samples the new level.
- R3: With the flag held high, `wr_permit` goes to 1 after the rising edge numbered SYNC_STAGES + HOLD_CYCLES, counting from the first edge that samples the flag high. Before that edge it stays 0.
- R4: `wr_permit` is 0 whenever the synchronised flag is 0. After the raw flag drops, it falls after the second rising edge.
- R5: If the synchronised flag drops during the hold-off, the count clears. The full HOLD_CYCLES wait starts again from zero once the flag returns.
- R6: `wr_grant` is 1 exactly when `wr_req` is 1 and `wr_permit` is 1, in the same cycle. This gates only the start of a write.
- R7: `rd_ok` equals `rd_req` in every cycle, whatever the supply flag and the hold-off state are.
- R8: When the synchronised flag falls while `wr_busy` is 1, `wr_abort` is 1 for exactly one cycle. This is the cycle in which `wr_permit` first reads 0. No pulse appears if `wr_busy` is 0 at that moment.
- R9: Once `wr_permit` is 1, it stays 1 for as long as the synchronised flag stays 1.
- R10: Asserting `rst_n` low clears `wr_permit` at once, without waiting for a clock edge. After release, the full synchroniser and hold-off sequence must run again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_ok_raw | input | 1 | Supply at or above lockout threshold, asynchronous to clk |
| wr_busy | input | 1 | A write is currently in progress in the memory core |
| wr_req | input | 1 | Request to start a write |
| rd_req | input | 1 | Request to start a read |
| wr_permit | output | 1 | Writes may start |
| wr_grant | output | 1 | Write start accepted this cycle |
| rd_ok | output | 1 | Read start accepted this cycle |
| wr_abort | output | 1 | One-cycle pulse: supply lost during a running write |

## Verification
If the hold-off counter holds a wrong value, `wr_permit` opens one or more cycles early or late compared with the edge count of R3 or R5. The bench samples right after that exact edge, so such an error shows up within a cycle. A synchroniser that is too short or too long moves every rise and fall of `wr_permit` by whole cycles, and this shows on the first supply change. A faulty edge detector either misses the `wr_abort` pulse, stretches it, or fires it with no write running. This shows on the cycle when permission falls.

// File: rtl/supply_gate_pkg.sv
package supply_gate_pkg;

  typedef enum logic [1:0] {
    PH_LOCKED = 2'd0,
    PH_WAIT   = 2'd1,
    PH_OPEN   = 2'd2
  } gate_phase_e;

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

endpackage

// File: rtl/sg_sync.sv
module sg_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[gi] <= 1'b0;
          else        chain_q[gi] <= chain_q[gi-1];
        end
      end
    end
  endgenerate

  assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/sg_holdoff_timer.sv
module sg_holdoff_timer
  import supply_gate_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sync_ok,
  output logic        permit,
  output gate_phase_e phase
);

  localparam int unsigned CW = cnt_width(HOLD_CYCLES);
  localparam logic [CW-1:0] HOLD_LIM = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt_q;
  logic          at_limit;

  assign at_limit = (cnt_q == HOLD_LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!sync_ok)   cnt_q <= '0;
    else if (!at_limit)  cnt_q <= cnt_q + 1'b1;
  end

  assign permit = sync_ok && at_limit;

  always_comb begin
    if (!sync_ok)      phase = PH_LOCKED;
    else if (at_limit) phase = PH_OPEN;
    else               phase = PH_WAIT;
  end

  // R3: permission opens only on the edge that completes the count
  p_open_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(permit) |-> ($past(cnt_q) == HOLD_LIM - 1'b1));

  // R5: a low flag leaves the count at zero on the next cycle
  p_dip_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_ok |=> (cnt_q == '0));

  // R9: permission is kept while the flag stays good
  p_stays_open_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(permit) && sync_ok) |-> permit);

endmodule

// File: rtl/sg_write_guard.sv
module sg_write_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_ok,
  input  logic permit,
  input  logic wr_busy,
  input  logic wr_req,
  input  logic rd_req,
  output logic wr_grant,
  output logic rd_ok,
  output logic wr_abort
);

  logic ok_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok_prev_q <= 1'b0;
    else        ok_prev_q <= sync_ok;
  end

  assign wr_grant = wr_req && permit;
  assign rd_ok    = rd_req;
  assign wr_abort = ok_prev_q && !sync_ok && wr_busy;

  // R8: the abort indication is a single-cycle pulse
  p_abort_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_abort |=> !wr_abort);

  // R8: an abort only follows a cycle in which the flag was good
  p_abort_after_good_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_abort |-> $past(sync_ok));

endmodule

// File: rtl/supply_write_gate.sv
module supply_write_gate
  import supply_gate_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 40_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok_raw,
  input  logic wr_busy,
  input  logic wr_req,
  input  logic rd_req,
  output logic wr_permit,
  output logic wr_grant,
  output logic rd_ok,
  output logic wr_abort
);

  logic        sync_ok;
  gate_phase_e phase;

  sg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (supply_ok_raw),
    .d_out (sync_ok)
  );

  sg_holdoff_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .sync_ok (sync_ok),
    .permit  (wr_permit),
    .phase   (phase)
  );

  sg_write_guard u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_ok  (sync_ok),
    .permit   (wr_permit),
    .wr_busy  (wr_busy),
    .wr_req   (wr_req),
    .rd_req   (rd_req),
    .wr_grant (wr_grant),
    .rd_ok    (rd_ok),
    .wr_abort (wr_abort)
  );

  // R4: no permission while the synchronised flag is low
  p_locked_when_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOCKED) |-> !wr_permit);

  // R8: an abort coincides with permission already withdrawn
  p_abort_closed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_abort |-> !wr_permit);

  // R6: a write start is never granted outside the open phase
  p_grant_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_grant |-> (phase == PH_OPEN));

endmodule

// File: tb/supply_write_gate_tb.sv
`timescale 1ns/1ps
module supply_write_gate_tb;

  localparam int unsigned HOLD = 8;
  localparam int NROWS = 13;

  // fields: raw[15] busy[14] wreq[13] rreq[12] cyc[11:4] permit[3] abort[2] grant[1] rd[0]
  localparam logic [15:0] VEC [NROWS] = '{
    {1'b1,1'b0,1'b1,1'b1, 8'd1, 1'b0,1'b0,1'b0,1'b1}, // first sample edge (R2)
    {1'b1,1'b0,1'b1,1'b0, 8'd1, 1'b0,1'b0,1'b0,1'b0}, // synced, count 0
    {1'b1,1'b0,1'b1,1'b1, 8'd7, 1'b0,1'b0,1'b0,1'b1}, // count 7, still shut (R3)
    {1'b1,1'b0,1'b1,1'b0, 8'd1, 1'b1,1'b0,1'b1,1'b0}, // opens (R3, R6)
    {1'b1,1'b0,1'b0,1'b1, 8'd5, 1'b1,1'b0,1'b0,1'b1}, // stays open (R9)
    {1'b0,1'b1,1'b1,1'b0, 8'd1, 1'b1,1'b0,1'b1,1'b0}, // drop seen by stage 1 only (R2)
    {1'b0,1'b1,1'b1,1'b1, 8'd1, 1'b0,1'b1,1'b0,1'b1}, // closed, abort (R4, R8)
    {1'b0,1'b1,1'b0,1'b0, 8'd1, 1'b0,1'b0,1'b0,1'b0}, // pulse over (R8)
    {1'b1,1'b0,1'b1,1'b1, 8'd6, 1'b0,1'b0,1'b0,1'b1}, // partial hold-off
    {1'b0,1'b0,1'b1,1'b0, 8'd1, 1'b0,1'b0,1'b0,1'b0}, // dip starts
    {1'b0,1'b0,1'b1,1'b1, 8'd1, 1'b0,1'b0,1'b0,1'b1}, // dip synced, no busy: no abort
    {1'b1,1'b0,1'b1,1'b0, 8'd9, 1'b0,1'b0,1'b0,1'b0}, // restarted, one short (R5)
    {1'b1,1'b0,1'b1,1'b1, 8'd1, 1'b1,1'b0,1'b1,1'b1}  // full wait done (R5)
  };

  logic clk = 1'b0;
  logic rst_n, supply_ok_raw, wr_busy, wr_req, rd_req;
  logic wr_permit, wr_grant, rd_ok, wr_abort;
  int n_checks = 0;
  int n_fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  supply_write_gate #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .supply_ok_raw(supply_ok_raw), .wr_busy(wr_busy),
    .wr_req(wr_req), .rd_req(rd_req), .wr_permit(wr_permit), .wr_grant(wr_grant),
    .rd_ok(rd_ok), .wr_abort(wr_abort)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; supply_ok_raw = 1'b0; wr_busy = 1'b0; wr_req = 1'b0; rd_req = 1'b0;
    #12;
    check("R1", "permit in reset", wr_permit, 1'b0);
    check("R1", "abort in reset", wr_abort, 1'b0);
    @(negedge clk); rst_n = 1'b1; wr_req = 1'b1;
    @(posedge clk); #1;
    check("R1", "permit after reset", wr_permit, 1'b0);
    check("R1", "grant after reset", wr_grant, 1'b0);

    for (int i = 0; i < NROWS; i++) begin
      @(negedge clk);
      supply_ok_raw = VEC[i][15];
      wr_busy       = VEC[i][14];
      wr_req        = VEC[i][13];
      rd_req        = VEC[i][12];
      repeat (int'(VEC[i][11:4])) @(posedge clk);
      #1;
      check("R2/R3/R4/R5/R9", $sformatf("permit row %0d", i), wr_permit, VEC[i][3]);
      check("R8", $sformatf("abort row %0d", i), wr_abort, VEC[i][2]);
      check("R6", $sformatf("grant row %0d", i), wr_grant, VEC[i][1]);
      check("R7", $sformatf("rd_ok row %0d", i), rd_ok, VEC[i][0]);
    end

    // R10: asynchronous reset while open
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R10", "permit drops in reset", wr_permit, 1'b0);
    check("R10", "grant drops in reset", wr_grant, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (9) @(posedge clk);
    #1;
    check("R10", "permit one edge before full wait", wr_permit, 1'b0);
    @(posedge clk); #1;
    check("R10", "permit after full wait", wr_permit, 1'b1);

    // R8: write busy but flag stays good gives no abort; R7 read while open
    @(negedge clk); wr_busy = 1'b1; rd_req = 1'b0;
    repeat (3) @(posedge clk); #1;
    check("R8", "no abort with steady supply", wr_abort, 1'b0);
    check("R7", "rd_ok low with no request", rd_ok, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule